// File: doc/BRIEF.md
# Physical Memory Attribute Checker

This block takes a physical address, the kind of access being attempted (instruction fetch, data load or data store) and a flag saying whether the access is still speculative. It reports which of three attribute classes the address belongs to: side-effecting I/O space, executable space and cacheable space. It also decides in the same cycle whether the access may be issued to the memory system. Each class is described by its own table of address windows. Every table has its own count of live entries, and all of its values are fixed when the design is elaborated. Nothing can change them while the design runs.

A fetch or load that is still speculative must never reach I/O space, because reading there can destroy device state. Such an access is held back: allow drops, no fault is raised, and the pipeline retries once the access is no longer speculative. A fetch outside every executable window is refused with a fault. An address that matches no window is not treated as an error here; any error for unpopulated space comes back in the bus response. Every access is treated as non-coherent, and no atomicity or reservation attribute is produced.

Top module: `pma_attr_checker`

## Requirements
- R1: An address lies in a window when base <= address < base + length, compared unsigned with one carry bit more than the address, so that the upper bound is exclusive and a window ending exactly at the top of the address space does not wrap.
- R2: Only entries with an index below a table's live-entry count take part in matching; entries at or above it are ignored whatever values they hold.
- R3: io_region_o is high exactly when the address lies in a live I/O window.
- R4: exec_region_o is high exactly when the address lies in a live executable window.
- R5: cacheable_o is high when the address lies in a live cacheable window and in no live I/O window; an I/O address is always reported uncached.
- R6: A speculative fetch or load to an I/O address is held back: allow_o is low, and fetch_fault_o is low unless R9 applies.
- R7: A non-speculative load or store to an I/O address has allow_o high.
- R8: A store is never held back by the speculative flag; a store always has allow_o high.
- R9: A fetch to an address outside every live executable window has fetch_fault_o high and allow_o low.
- R10: A load or store to an address in no window at all has allow_o high and fetch_fault_o low (no local vacant-space check).
- R11: fetch_fault_o is never high for a load or store.
- R12: All outputs depend combinationally on address, access kind and speculative flag, with no clock cycle of latency.
- R13: The access kind is encoded 2'b00 fetch, 2'b01 load, 2'b10 store; the unused code 2'b11 is handled exactly as a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | ADDR_W | Physical address of the access |
| acc_kind_i | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 treated as load |
| spec_i | input | 1 | High while the access is still speculative |
| io_region_o | output | 1 | Address lies in a live I/O window |
| exec_region_o | output | 1 | Address lies in a live executable window |
| cacheable_o | output | 1 | Address may be cached (cacheable and not I/O) |
| allow_o | output | 1 | Access may be issued now |
| fetch_fault_o | output | 1 | Fetch outside executable space |

## Verification
The hardest cases to reach from the ports are the ones set by the parameter tables rather than the inputs: table entries above the live count, window edges, and a window whose end coincides with the top of the address space. The default tables are built for this. Each class holds a dormant entry with real values that would change the outcome if it were wrongly honoured. One executable window ends at the top of the address space. An I/O window sits inside a cacheable window. The stimulus table then places addresses on the first byte, last byte and first byte past these windows, and repeats the I/O addresses with the speculative flag both set and clear.

// File: rtl/pma_chk_pkg.sv
package pma_chk_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic io;
    logic exec;
    logic cache;
  } class_hits_t;

endpackage

// File: rtl/pma_rule_match.sv
module pma_rule_match #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MAX_RULES = 4,
  parameter int unsigned ACTIVE    = 1,
  parameter logic [MAX_RULES-1:0][ADDR_W-1:0] BASE = '0,
  parameter logic [MAX_RULES-1:0][ADDR_W-1:0] LEN  = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);

  localparam int unsigned EXT_W = ADDR_W + 1;
  localparam int unsigned USED  = (ACTIVE > MAX_RULES) ? MAX_RULES : ACTIVE;

  logic [MAX_RULES-1:0] rule_hit;
  logic [EXT_W-1:0]     addr_ext;

  assign addr_ext = {1'b0, addr_i};

  for (genvar i = 0; i < MAX_RULES; i++) begin : g_rule
    if (i < USED) begin : g_live
      logic [EXT_W-1:0] lo_bound;
      logic [EXT_W-1:0] hi_bound;
      assign lo_bound    = {1'b0, BASE[i]};
      assign hi_bound    = {1'b0, BASE[i]} + {1'b0, LEN[i]};
      assign rule_hit[i] = (addr_ext >= lo_bound) && (addr_ext < hi_bound);
    end else begin : g_dormant
      assign rule_hit[i] = 1'b0;
    end
  end

  assign hit_o = |rule_hit;

endmodule

// File: rtl/pma_access_gate.sv
module pma_access_gate
  import pma_chk_pkg::*;
(
  input  class_hits_t hits_i,
  input  logic [1:0]  acc_kind_i,
  input  logic        spec_i,
  output logic        io_region_o,
  output logic        exec_region_o,
  output logic        cacheable_o,
  output logic        allow_o,
  output logic        fetch_fault_o
);

  acc_kind_e kind;
  logic      is_fetch;
  logic      is_store;
  logic      held;

  assign kind = acc_kind_e'(acc_kind_i);

  always_comb begin
    is_fetch = 1'b0;
    is_store = 1'b0;
    unique case (kind)
      ACC_FETCH: is_fetch = 1'b1;
      ACC_STORE: is_store = 1'b1;
      default:   ;
    endcase
  end

  assign held          = spec_i & hits_i.io & ~is_store;
  assign io_region_o   = hits_i.io;
  assign exec_region_o = hits_i.exec;
  assign cacheable_o   = hits_i.cache & ~hits_i.io;
  assign fetch_fault_o = is_fetch & ~hits_i.exec;
  assign allow_o       = ~fetch_fault_o & ~held;

  always_comb begin
    if (fetch_fault_o) AST_FAULT_BLOCKS: assert (!allow_o); // R9
    if (fetch_fault_o) AST_FAULT_FETCH_ONLY: assert (acc_kind_i == 2'b00); // R11
    if (spec_i && hits_i.io && acc_kind_i != 2'b10) AST_SPEC_IO_HELD: assert (!allow_o); // R6
    if (hits_i.io) AST_IO_UNCACHED: assert (!cacheable_o); // R5
    if (acc_kind_i == 2'b10) AST_STORE_ISSUES: assert (allow_o && !fetch_fault_o); // R8
    if (acc_kind_i == 2'b11) AST_RSVD_NO_FAULT: assert (!fetch_fault_o); // R13
  end

endmodule

// File: rtl/pma_attr_checker.sv
module pma_attr_checker
  import pma_chk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MAX_RULES = 4,
  parameter int unsigned IO_RULES  = 2,
  parameter logic [MAX_RULES-1:0][ADDR_W-1:0] IO_BASE = {
    32'h0000_0000, 32'h8000_0000, 32'h0C00_0000, 32'h1000_0000},
  parameter logic [MAX_RULES-1:0][ADDR_W-1:0] IO_LEN = {
    32'h0000_0000, 32'h0000_0100, 32'h0400_0000, 32'h0000_1000},
  parameter int unsigned EXEC_RULES = 3,
  parameter logic [MAX_RULES-1:0][ADDR_W-1:0] EXEC_BASE = {
    32'h1000_0000, 32'hF000_0000, 32'h8000_0000, 32'h0001_0000},
  parameter logic [MAX_RULES-1:0][ADDR_W-1:0] EXEC_LEN = {
    32'h0000_1000, 32'h1000_0000, 32'h4000_0000, 32'h0001_0000},
  parameter int unsigned CACHE_RULES = 2,
  parameter logic [MAX_RULES-1:0][ADDR_W-1:0] CACHE_BASE = {
    32'h0000_0000, 32'h0001_0000, 32'h1000_0000, 32'h8000_0000},
  parameter logic [MAX_RULES-1:0][ADDR_W-1:0] CACHE_LEN = {
    32'h0000_0000, 32'h0001_0000, 32'h0010_0000, 32'h4000_0000}
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        acc_kind_i,
  input  logic              spec_i,
  output logic              io_region_o,
  output logic              exec_region_o,
  output logic              cacheable_o,
  output logic              allow_o,
  output logic              fetch_fault_o
);

  class_hits_t hits;

  pma_rule_match #(
    .ADDR_W(ADDR_W), .MAX_RULES(MAX_RULES), .ACTIVE(IO_RULES),
    .BASE(IO_BASE), .LEN(IO_LEN)
  ) i_io_match (
    .addr_i(addr_i),
    .hit_o (hits.io)
  );

  pma_rule_match #(
    .ADDR_W(ADDR_W), .MAX_RULES(MAX_RULES), .ACTIVE(EXEC_RULES),
    .BASE(EXEC_BASE), .LEN(EXEC_LEN)
  ) i_exec_match (
    .addr_i(addr_i),
    .hit_o (hits.exec)
  );

  pma_rule_match #(
    .ADDR_W(ADDR_W), .MAX_RULES(MAX_RULES), .ACTIVE(CACHE_RULES),
    .BASE(CACHE_BASE), .LEN(CACHE_LEN)
  ) i_cache_match (
    .addr_i(addr_i),
    .hit_o (hits.cache)
  );

  pma_access_gate i_gate (
    .hits_i       (hits),
    .acc_kind_i   (acc_kind_i),
    .spec_i       (spec_i),
    .io_region_o  (io_region_o),
    .exec_region_o(exec_region_o),
    .cacheable_o  (cacheable_o),
    .allow_o      (allow_o),
    .fetch_fault_o(fetch_fault_o)
  );

endmodule

// File: tb/test_pma_attr_checker.sv
module test_pma_attr_checker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] addr = '0;
  logic [1:0]  kind = 2'b01;
  logic        spec = 1'b0;
  logic        io_o, ex_o, ca_o, al_o, ff_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pma_attr_checker i_pma_attr_checker (
    .addr_i       (addr),
    .acc_kind_i   (kind),
    .spec_i       (spec),
    .io_region_o  (io_o),
    .exec_region_o(ex_o),
    .cacheable_o  (ca_o),
    .allow_o      (al_o),
    .fetch_fault_o(ff_o)
  );

  // {addr, kind, spec, expected {io,exec,cache,allow,fault}, tag}
  localparam int NV = 22;
  localparam logic [63:0] VEC [NV] = '{
    {32'h8000_0000, 2'b00, 1'b0, 5'b01110, "R4 "},
    {32'h8000_0000, 2'b01, 1'b1, 5'b01110, "R2 "},
    {32'hBFFF_FFFF, 2'b00, 1'b0, 5'b01110, "R1 "},
    {32'hC000_0000, 2'b00, 1'b0, 5'b00001, "R9 "},
    {32'hC000_0000, 2'b01, 1'b0, 5'b00010, "R10"},
    {32'h1000_0000, 2'b01, 1'b1, 5'b10000, "R6 "},
    {32'h1000_0000, 2'b01, 1'b0, 5'b10010, "R7 "},
    {32'h1000_0FFF, 2'b10, 1'b1, 5'b10010, "R8 "},
    {32'h1000_1000, 2'b01, 1'b1, 5'b00110, "R1 "},
    {32'h1000_0000, 2'b00, 1'b0, 5'b10001, "R2 "},
    {32'h0C00_0000, 2'b01, 1'b1, 5'b10000, "R3 "},
    {32'h0FFF_FFFF, 2'b01, 1'b0, 5'b10010, "R3 "},
    {32'h0001_0000, 2'b00, 1'b1, 5'b01010, "R2 "},
    {32'h0000_FFFF, 2'b00, 1'b0, 5'b00001, "R9 "},
    {32'hFFFF_FFFF, 2'b00, 1'b1, 5'b01010, "R1 "},
    {32'h0001_FFFF, 2'b00, 1'b0, 5'b01010, "R4 "},
    {32'h0002_0000, 2'b00, 1'b0, 5'b00001, "R1 "},
    {32'hFFFF_FFFF, 2'b10, 1'b0, 5'b01010, "R11"},
    {32'h1000_0000, 2'b11, 1'b1, 5'b10000, "R13"},
    {32'hC000_0000, 2'b11, 1'b0, 5'b00010, "R13"},
    {32'h1000_0800, 2'b10, 1'b0, 5'b10010, "R5 "},
    {32'h1000_0000, 2'b00, 1'b1, 5'b10001, "R6 "}
  };

  task automatic check(input logic [4:0] exp, input logic [23:0] tag);
    logic [4:0] act;
    act = {io_o, ex_o, ca_o, al_o, ff_o};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h kind=%b spec=%b got=%b expected=%b",
               tag, addr, kind, spec, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [1:0] k, input logic s);
    @(negedge clk);
    addr = a;
    kind = k;
    spec = s;
    #1;
  endtask

  initial begin
    // Idle inputs during bench reset: load at 0, no window, R10
    repeat (3) @(posedge clk);
    #1;
    check(5'b00010, "R10");
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][63:32], VEC[v][31:30], VEC[v][29]);
      check(VEC[v][28:24], VEC[v][23:0]);
    end

    // R12: flip speculative flag on an I/O load, result changes within the cycle
    apply(32'h1000_0004, 2'b01, 1'b1);
    check(5'b10000, "R12");
    @(negedge clk);
    spec = 1'b0;
    #1;
    check(5'b10010, "R12");
    addr = 32'h9000_0000;
    #1;
    check(5'b01110, "R12");

    // R2: I/O window with index beyond live count (0x8000_00xx) stays non-I/O and cacheable
    apply(32'h8000_00FF, 2'b01, 1'b1);
    check(5'b01110, "R2");

    // R5: cacheable window overlapping I/O window reports uncached at I/O, cached past it
    apply(32'h1000_0FFF, 2'b01, 1'b0);
    check(5'b10010, "R5");
    apply(32'h100F_FFFF, 2'b01, 1'b0);
    check(5'b00110, "R5");
    apply(32'h1010_0000, 2'b01, 1'b0);
    check(5'b00010, "R5");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule